// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block sits between a host and a modulator. The host pushes whole bytes into a 64-entry queue. The block sends them one after another as a plain NRZ bit stream on `ser_out`, one bit for each pulse of an external bit-rate strobe, most significant bit first. The block adds no framing. Preamble, sync pattern and payload all arrive from the host as ordinary bytes. No length, address or checksum logic is present. Bytes keep flowing for as long as the queue holds data, so a stream can have any length.

A configuration pin chooses when sending begins. In one policy it begins as soon as one byte is queued. In the other it begins only once the queue is full, and after that it drains without stopping. Two level interrupts report progress. `irq_drained` rises when the last queued byte moves into the shift register, which leaves the host eight bit periods to add more. `irq_done` rises when the last bit of the last byte has used up its bit period. Dropping `tx_on` aborts at once and throws away everything queued.

The write side uses valid/ready. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the queue is full or the block is disabled. A host that raises `in_valid` while `in_ready` is low, with the block enabled, loses that byte, and the sticky `overflow` flag records the loss. The host may hold or drop `in_valid` freely while `in_ready` is low.

Top module: `fifo_ser_tx`

## Requirements
- R1: After reset, and whenever `tx_on` is low, `ser_out`, `irq_drained`, `irq_done`, `overflow` and `in_ready` are all 0. With `tx_on` high and an empty queue, `in_ready` is 1.
- R2: Each byte is sent most significant bit first. Each bit appears on `ser_out` in the clock cycle after the strobe that presents it, and holds until the next strobe.
- R3: Consecutive queued bytes follow with no idle bit. The next byte loads on the strobe that ends the previous byte's last bit.
- R4: With `start_full`=0, sending begins on the first strobe that arrives at least two cycles after the first byte is accepted.
- R5: With `start_full`=1, `ser_out` stays 0 while fewer than 64 bytes are queued. Once 64 bytes are queued, all of them are sent back to back, exactly 512 bits.
- R6: `irq_drained` goes to 1 on the strobe that loads the last queued byte into the shift register. It goes back to 0 when a byte is accepted.
- R7: `irq_done` goes to 1 on the strobe after the last bit period of the last byte, when no byte is queued. At that point `ser_out` returns to 0. A byte accepted after `irq_drained` but before that strobe is sent right after the current byte, with no gap.
- R8: `in_ready` is 0 while 64 bytes are queued. A valid byte offered then is dropped, and `overflow` goes to 1 and stays there until `tx_on` falls.
- R9: When `tx_on` falls, `ser_out` goes to 0 in the same cycle. The queue is then emptied, the byte in progress is dropped, and both interrupts and `overflow` clear. After `tx_on` rises again, strobes send nothing until new bytes are written.
- R10: With `start_full`=1, the full-queue start latch re-arms only after `irq_done`. A single byte written after a completed stream is not sent until the queue fills again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_on | input | 1 | Transmit enable; low aborts and clears |
| start_full | input | 1 | Start policy: 0 = first byte, 1 = full queue |
| bit_stb | input | 1 | One-cycle bit-rate strobe |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Queue can accept a byte |
| ser_out | output | 1 | NRZ serial data, idles low |
| irq_drained | output | 1 | Level: last queued byte moved to shift register |
| irq_done | output | 1 | Level: final bit has finished |
| overflow | output | 1 | Sticky: a byte was offered while full |

## Verification
A queue pointer or count that goes wrong shows up on `ser_out` within one byte time. The bit pattern turns wrong, repeats, or stops early, and the stream's total bit count no longer matches the number of bytes written. A wrong bit counter or load rule shows within eight strobes, as a gap, a shifted bit, or `irq_done` arriving on the wrong strobe. A start latch or interrupt flag held in the wrong state is caught at the first strobe after the write or the final bit. The tests compare the port values against patterns worked out ahead of time, strobe by strobe.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic {
    POL_FIRST = 1'b0,
    POL_FULL  = 1'b1
  } start_pol_e;
endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;

  // R8: occupancy grows by exactly one per lone write
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> (cnt == $past(cnt) + CW'(1)));
  // R8: occupancy never exceeds the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         start_ok,
  input  logic         have_data,
  input  logic [W-1:0] load_data,
  output logic         pop,
  output logic         sdo_bit,
  output logic         busy,
  output logic         done_pulse
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;
  logic          last_bit, load;

  assign last_bit   = busy && (left == '0);
  assign load       = tick && have_data && ((!busy && start_ok) || last_bit);
  assign done_pulse = tick && last_bit && !have_data;
  assign pop        = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; left <= '0; busy <= 1'b0;
    end else if (clr) begin
      shreg <= '0; left <= '0; busy <= 1'b0;
    end else if (load) begin
      shreg <= load_data;
      left  <= CW'(W-1);
      busy  <= 1'b1;
    end else if (done_pulse) begin
      shreg <= '0;
      busy  <= 1'b0;
    end else if (tick && busy) begin
      shreg <= {shreg[W-2:0], 1'b0};
      left  <= left - CW'(1);
    end
  end

  assign sdo_bit = busy & shreg[W-1];

  // R2: without a strobe the output state holds
  a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> ($stable(shreg) && $stable(busy) && $stable(left)));
  // R9: disable empties the shifter
  a_r9_shifter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && shreg == '0));
endmodule

// File: rtl/fifo_ser_tx.sv
module fifo_ser_tx
  import ftx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_on,
  input  logic         start_full,
  input  logic         bit_stb,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         ser_out,
  output logic         irq_drained,
  output logic         irq_done,
  output logic         overflow
);
  localparam int CW = $clog2(DEPTH+1);

  start_pol_e    pol;
  logic          clr, push, pop, f_empty, f_full;
  logic [W-1:0]  f_rdata;
  logic [CW-1:0] f_count;
  logic          go_q, start_cond;
  logic          sh_bit, sh_busy, sh_done;
  logic          drained_q, done_q, ovf_q;

  assign pol      = start_pol_e'(start_full);
  assign clr      = !tx_on;
  assign in_ready = tx_on && !f_full;
  assign push     = in_valid && in_ready;

  ftx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .wdata(in_data),
    .pop(pop), .rdata(f_rdata), .empty(f_empty), .full(f_full), .count(f_count)
  );

  ftx_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(bit_stb), .start_ok(go_q),
    .have_data(!f_empty), .load_data(f_rdata), .pop(pop), .sdo_bit(sh_bit),
    .busy(sh_busy), .done_pulse(sh_done)
  );

  assign start_cond = (pol == POL_FULL) ? f_full : !f_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; drained_q <= 1'b0; done_q <= 1'b0; ovf_q <= 1'b0;
    end else if (clr) begin
      go_q <= 1'b0; drained_q <= 1'b0; done_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      if (sh_done)         go_q <= 1'b0;
      else if (start_cond) go_q <= 1'b1;

      if (pop && f_count == CW'(1) && !push) drained_q <= 1'b1;
      else if (push)                         drained_q <= 1'b0;

      if (sh_done)   done_q <= 1'b1;
      else if (push) done_q <= 1'b0;

      if (in_valid && !in_ready) ovf_q <= 1'b1;
    end
  end

  assign ser_out     = tx_on & sh_bit;
  assign irq_drained = drained_q;
  assign irq_done    = done_q;
  assign overflow    = ovf_q;

  // R4: a stream only begins after the start latch was armed
  a_r4_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_busy) |-> $past(go_q));
  // R6: drained flag implies an empty queue
  a_r6_drained_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drained |-> f_empty);
  // R8: a refused offer marks overflow
  a_r8_refused_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && tx_on) |=> overflow);
  // R9: disable clears flags and shifter
  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> (!sh_busy && !irq_drained && !irq_done && !overflow));
  // R7: completion flag only when the shifter is idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !sh_busy);
endmodule

// File: tb/test_fifo_ser_tx.sv
`timescale 1ns/1ps
module test_fifo_ser_tx;
  logic clk = 1'b0, rst_n = 1'b0, tx_on = 1'b0, start_full = 1'b0;
  logic bit_stb = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, ser_out, irq_drained, irq_done, overflow;
  int checks = 0, errors = 0;
  logic [7:0] pat [64];

  always #2.5 clk = ~clk;

  fifo_ser_tx i_fifo_ser_tx (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .start_full(start_full),
    .bit_stb(bit_stb), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ser_out(ser_out), .irq_drained(irq_drained),
    .irq_done(irq_done), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic restart(input logic pol);
    @(negedge clk); tx_on = 1'b0; start_full = pol;
    idle(2); tx_on = 1'b1; idle(1);
  endtask

  // stream the first n bytes of pat, checking every bit and both interrupts
  task automatic expect_stream(input int n, input string tag);
    for (int t = 1; t <= 8*n; t++) begin
      if (t == 8*(n-1) + 1) chk({tag, " R6 drained before last load"}, irq_drained, 0);
      strobe();
      chk({tag, " R2 R3 bit"}, ser_out, pat[(t-1)/8][7 - ((t-1)%8)]);
      if (t == 8*(n-1) + 1) chk({tag, " R6 drained at last load"}, irq_drained, 1);
      chk({tag, " R7 no early done"}, irq_done, 0);
      idle(2);
      chk({tag, " R2 hold"}, ser_out, pat[(t-1)/8][7 - ((t-1)%8)]);
    end
    strobe();
    chk({tag, " R7 done"}, irq_done, 1);
    chk({tag, " R7 idle low"}, ser_out, 0);
  endtask

  task automatic t_reset();
    chk("R1 ser_out", ser_out, 0);
    chk("R1 drained", irq_drained, 0);
    chk("R1 done", irq_done, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 ready off", in_ready, 0);
    tx_on = 1'b1; idle(1);
    chk("R1 ready on", in_ready, 1);
  endtask

  task automatic t_first_byte();
    restart(1'b0);
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h81;
    for (int i = 0; i < 3; i++) push(pat[i]);
    idle(2);
    expect_stream(3, "R4 first");
  endtask

  task automatic t_late_write();
    restart(1'b0);
    pat[0] = 8'hC6; pat[1] = 8'h5B;
    push(pat[0]); idle(2);
    strobe();
    chk("R6 drained single", irq_drained, 1);
    chk("R2 first bit", ser_out, pat[0][7]);
    push(pat[1]);
    chk("R6 cleared by write", irq_drained, 0);
    for (int t = 2; t <= 16; t++) begin
      strobe();
      chk("R7 no gap", ser_out, pat[(t-1)/8][7 - ((t-1)%8)]);
      if (t == 9) chk("R6 drained second", irq_drained, 1);
    end
    strobe();
    chk("R7 done after late", irq_done, 1);
  endtask

  task automatic t_full_start();
    restart(1'b1);
    for (int i = 0; i < 64; i++) pat[i] = 8'((i * 37 + 11) ^ (i << 3));
    for (int i = 0; i < 63; i++) push(pat[i]);
    for (int k = 0; k < 10; k++) begin
      strobe();
      chk("R5 waits for full", ser_out, 0);
    end
    push(pat[63]);
    chk("R8 not ready when full", in_ready, 0);
    chk("R8 flag clear before", overflow, 0);
    push(8'hFF);
    chk("R8 overflow set", overflow, 1);
    idle(2);
    expect_stream(64, "R5 full");
    chk("R8 overflow sticky", overflow, 1);
    push(8'hF0); idle(2);
    for (int k = 0; k < 12; k++) begin
      strobe();
      chk("R10 no rearm", ser_out, 0);
    end
    @(negedge clk); tx_on = 1'b0; idle(1);
    chk("R9 overflow cleared", overflow, 0);
  endtask

  task automatic t_abort();
    restart(1'b0);
    push(8'hFF); push(8'hFF); push(8'hFF); idle(2);
    for (int k = 0; k < 5; k++) strobe();
    chk("R9 sending before abort", ser_out, 1);
    @(negedge clk); tx_on = 1'b0; #1;
    chk("R9 immediate low", ser_out, 0);
    idle(1);
    chk("R9 drained clear", irq_drained, 0);
    chk("R9 ready off", in_ready, 0);
    tx_on = 1'b1; idle(2);
    for (int k = 0; k < 20; k++) begin
      strobe();
      chk("R9 queue discarded", ser_out, 0);
    end
    chk("R9 no done", irq_done, 0);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset();
    t_first_byte();
    t_late_write();
    t_full_start();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule